// File: doc/BRIEF.md
# Margin Verify Command Engine

This block takes in a bit-serial reader command that asks the tag to confirm that a stretch of stored bits is both correct and written with enough programming margin. As the bits arrive it parses the opcode, a bank selector, a start pointer coded as an extensible bit vector, a mask length, the mask itself and a session handle. While the mask streams in, it reads each addressed memory bit through a margin-mode read port and folds any value mismatch or weak margin into a sticky flag. No mask storage is needed.

When the frame-end strobe arrives, the engine combines several inputs: the parse outcome, the external CRC verdict, the tag's protocol state, the supply state and the bank lock. From these it either stays silent, returns an error reply (header 1 plus an error code), or returns a pass reply (header 0). Every reply echoes the handle. The reply is a one-cycle parallel pulse that a downstream encoder serialises; that encoder also appends the CRC.

Top module: `mrv_engine`

## Requirements
- R1: Reset state. After reset `rsp_vld` is low, and the parser waits for the first opcode bit.
- R2: Opcode check. A frame whose first 16 bits (first bit = MSB) are not 1110000000000001 produces no reply.
- R3: Field order and addressing. The field order is: opcode, 2-bit bank, pointer, 8-bit length (MSB first), mask, 16-bit handle (MSB first). Bank codes are 00 reserved, 01 EPC, 10 TID and 11 user. The bank drives `mem_bank`. The i-th mask bit received (i from 0) is compared with the memory bit at address pointer+i.
- R4: Pointer coding. The pointer is sent in 8-bit blocks. The first bit of each block is an extension flag (1 means another block follows), followed by 7 data bits, MSB first, most significant block first. At most 3 blocks are allowed; a frame whose third block still has the extension flag set is ignored.
- R5: Length. A length of 0 makes the command silent. Lengths 1 to 255 are executed.
- R6: Frame validity. The command is silent in any of these cases: the handle differs from `cur_handle`, `crc_ok` is low, or the frame carries bits beyond the handle.
- R7: Tag state. The command is silent when `tag_active` (open or secured state) is low.
- R8: Power. For an otherwise valid frame with `pwr_good` low, the reply is an error with code 8'h0B. This takes precedence over the lock and mask outcomes.
- R9: Margin check. If any mask bit differs from the stored bit, or `mem_margin_ok` is low for any masked bit, the reply is an error with code 8'h00.
- R10: Lock. A reserved-bank command while `rsv_rd_lock` is high returns error code 8'h00.
- R11: Reply format. A passing command replies with `rsp_hdr`=0. Every reply carries the frame's handle on `rsp_handle`. `rsp_vld` pulses for one cycle, in the cycle after the `cmd_end` cycle. `crc_ok`, `tag_active`, `pwr_good`, `rsv_rd_lock` and `cur_handle` are sampled in the `cmd_end` cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_vld | input | 1 | One command bit is present |
| cmd_bit | input | 1 | Command bit value |
| cmd_end | input | 1 | Frame end strobe; never in the same cycle as `cmd_vld` |
| crc_ok | input | 1 | CRC-16 of the frame is correct |
| tag_active | input | 1 | Tag is in open or secured state |
| cur_handle | input | 16 | Handle of the current session |
| pwr_good | input | 1 | Supply is sufficient to execute |
| rsv_rd_lock | input | 1 | Reserved (password) bank is read-locked |
| mem_rd | output | 1 | Margin-mode read strobe, one per mask bit |
| mem_bank | output | 2 | Bank being read |
| mem_addr | output | 21 | Bit address being read |
| mem_bit | input | 1 | Stored bit at `mem_addr` (same-cycle read) |
| mem_margin_ok | input | 1 | Addressed bit has sufficient margin |
| rsp_vld | output | 1 | Reply pulse |
| rsp_hdr | output | 1 | Reply header: 0 pass, 1 error |
| rsp_code | output | 8 | Error code when `rsp_hdr`=1 |
| rsp_handle | output | 16 | Echoed handle |

## Verification
On every cycle, the assertions check the following:
- the reply is a single-cycle pulse that follows a frame end;
- a pass reply never follows a low supply, a lock hit or a failed mask;
- a power error never follows a good supply;
- an inactive tag, a zero length or a foreign handle leaves the reply silent;
- the read address steps by one for each mask bit;
- the failure flag stays sticky within a frame.

Only the bench scenarios can show the rest. These include exact error codes, pointer decoding across one, two and three blocks, overflow of the block count, and the full 255-bit length. They also include margin failures at specific addresses, and parser recovery after ignored frames.

// File: rtl/mrv_pkg.sv
// Shared constants and parser state type for the margin verify engine.
package mrv_pkg;
    localparam logic [15:0] MRV_OPCODE = 16'b1110000000000001;
    localparam logic [7:0]  ERR_POWER  = 8'h0B;
    localparam logic [7:0]  ERR_OTHER  = 8'h00;
    localparam logic [1:0]  BANK_RSV   = 2'b00;

    typedef enum logic [2:0] {
        P_OP, P_BANK, P_PTR, P_LEN, P_MASK, P_HDL, P_DONE, P_SKIP
    } pstate_t;
endpackage

// File: rtl/mrv_ebv.sv
// Extensible bit vector decoder.
// Each block carries an extension flag followed by BLK_W-1 data bits, MSB first.
// Assumes the caller feeds bits only while the pointer field is being received.
// The caller also clears the decoder between frames.
module mrv_ebv #(
    parameter int BLK_MAX = 3,
    parameter int BLK_W   = 8,
    localparam int VAL_W  = BLK_MAX * (BLK_W - 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             bit_vld,
    input  logic             bit_in,
    output logic [VAL_W-1:0] val,
    output logic             done,
    output logic             ovf
);
    localparam int CW = $clog2(BLK_W);
    localparam int NW = $clog2(BLK_MAX + 1);

    logic [CW-1:0] bpos;
    logic [NW-1:0] nblk;
    logic          ext;
    logic          last;

    // End-of-block detection and the done / overflow outcome of a block
    always_comb begin
        last = bit_vld && (bpos == CW'(BLK_W - 1));
        done = last && !ext;
        ovf  = last && ext && (nblk == NW'(BLK_MAX - 1));
    end

    // Capture the extension flag and shift in data bits
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            bpos <= '0;
            nblk <= '0;
            ext  <= 1'b0;
            val  <= '0;
        end else if (bit_vld) begin
            if (bpos == '0) ext <= bit_in;
            else            val <= {val[VAL_W-2:0], bit_in};
            bpos <= last ? '0 : bpos + 1'b1;
            if (last) nblk <= nblk + 1'b1;
        end
    end

    // R4: the decoded value changes only when a bit arrives
    p_val_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!bit_vld && !clr) |=> $stable(val));
endmodule

// File: rtl/mrv_margin_acc.sv
// Streams the mask against memory.
// For each mask bit it drives address base+index and compares the returned bit,
// and it records any mismatch or weak margin in a sticky flag.
// Assumes a same-cycle (combinational) margin read port and a base held stable during the mask.
module mrv_margin_acc #(
    parameter int ADDR_W = 21,
    parameter int LEN_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic [ADDR_W-1:0] base,
    input  logic              step,
    input  logic              mask_bit,
    input  logic              mem_bit,
    input  logic              mem_margin_ok,
    output logic [ADDR_W-1:0] addr,
    output logic              bad
);
    logic [LEN_W-1:0] idx;

    // Current bit address
    assign addr = base + ADDR_W'(idx);

    // Advance the index and accumulate failures
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            idx <= '0;
            bad <= 1'b0;
        end else if (step) begin
            idx <= idx + 1'b1;
            if ((mask_bit != mem_bit) || !mem_margin_ok) bad <= 1'b1;
        end
    end

    // R3: consecutive mask bits address consecutive memory bits
    p_addr_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !clr) |=> (addr == $past(addr) + 1'b1) || clr);
    // R9: a failure stays recorded until the frame is cleared
    p_bad_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (bad && !clr) |=> bad);
endmodule

// File: rtl/mrv_reply.sv
// Final decision and reply register.
// Silent conditions are checked first, then power, then lock or mask failure; otherwise the command passes.
// Assumes fire is a single-cycle strobe at the end of a fully parsed frame.
module mrv_reply
    import mrv_pkg::*;
#(
    parameter int HDL_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fire,
    input  logic             crc_ok,
    input  logic             len_zero,
    input  logic             hdl_match,
    input  logic             tag_active,
    input  logic             pwr_good,
    input  logic             lock_hit,
    input  logic             mask_bad,
    input  logic [HDL_W-1:0] hdl,
    output logic             rsp_vld,
    output logic             rsp_hdr,
    output logic [7:0]       rsp_code,
    output logic [HDL_W-1:0] rsp_handle
);
    logic silent;

    // Conditions under which the command gets no reply at all
    assign silent = !crc_ok || len_zero || !hdl_match || !tag_active;

    // Register the reply for one cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_vld    <= 1'b0;
            rsp_hdr    <= 1'b0;
            rsp_code   <= '0;
            rsp_handle <= '0;
        end else begin
            rsp_vld <= fire && !silent;
            if (fire && !silent) begin
                rsp_handle <= hdl;
                if (!pwr_good) begin
                    rsp_hdr  <= 1'b1;
                    rsp_code <= ERR_POWER;
                end else if (lock_hit || mask_bad) begin
                    rsp_hdr  <= 1'b1;
                    rsp_code <= ERR_OTHER;
                end else begin
                    rsp_hdr  <= 1'b0;
                    rsp_code <= 8'h00;
                end
            end
        end
    end

    // R11: a pass never follows low power, a lock hit or a failed mask
    p_pass_clean_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_vld && !rsp_hdr) |-> ($past(pwr_good) && !$past(lock_hit) && !$past(mask_bad)));
    // R8: the power error only follows a low supply
    p_power_err_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_vld && rsp_hdr && rsp_code == ERR_POWER) |-> !$past(pwr_good));
    // R6: a foreign handle stays silent
    p_foreign_handle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && !hdl_match) |=> !rsp_vld);
endmodule

// File: rtl/mrv_engine.sv
// Margin verify command engine, top level.
// Parses a bit-serial command (opcode, bank, extensible-bit-vector pointer, length, mask, handle),
// streams the mask against a margin-mode memory port, and issues a pass, an error or no reply.
// Assumes cmd_end never coincides with cmd_vld and that the CRC is judged outside (crc_ok).
module mrv_engine
    import mrv_pkg::*;
#(
    parameter int EBV_BLOCKS = 3,
    parameter int EBV_BLK_W  = 8,
    parameter int LEN_W      = 8,
    parameter int HDL_W      = 16,
    localparam int ADDR_W    = EBV_BLOCKS * (EBV_BLK_W - 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_vld,
    input  logic              cmd_bit,
    input  logic              cmd_end,
    input  logic              crc_ok,
    input  logic              tag_active,
    input  logic [HDL_W-1:0]  cur_handle,
    input  logic              pwr_good,
    input  logic              rsv_rd_lock,
    output logic              mem_rd,
    output logic [1:0]        mem_bank,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_bit,
    input  logic              mem_margin_ok,
    output logic              rsp_vld,
    output logic              rsp_hdr,
    output logic [7:0]        rsp_code,
    output logic [HDL_W-1:0]  rsp_handle
);
    localparam int OP_W = $bits(MRV_OPCODE);

    pstate_t           st;
    logic [LEN_W-1:0]  fcnt;
    logic [OP_W-1:0]   op;
    logic [1:0]        bank;
    logic [LEN_W-1:0]  len;
    logic [HDL_W-1:0]  hdl;
    logic [ADDR_W-1:0] ptr;
    logic              ebv_done, ebv_ovf, mask_bad, fire;
    logic [OP_W-1:0]   op_nxt;
    logic [LEN_W-1:0]  len_nxt;

    // Shift values as they will look once the current bit is taken
    assign op_nxt  = {op[OP_W-2:0], cmd_bit};
    assign len_nxt = {len[LEN_W-2:0], cmd_bit};

    // Field parser state machine
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st   <= P_OP;
            fcnt <= '0;
            op   <= '0;
            bank <= '0;
            len  <= '0;
            hdl  <= '0;
        end else if (cmd_end) begin
            st   <= P_OP;
            fcnt <= '0;
        end else if (cmd_vld) begin
            case (st)
                P_OP: begin
                    op <= op_nxt;
                    if (fcnt == LEN_W'(OP_W - 1)) begin
                        fcnt <= '0;
                        st   <= (op_nxt == MRV_OPCODE) ? P_BANK : P_SKIP;
                    end else fcnt <= fcnt + 1'b1;
                end
                P_BANK: begin
                    bank <= {bank[0], cmd_bit};
                    if (fcnt == LEN_W'(1)) begin
                        fcnt <= '0;
                        st   <= P_PTR;
                    end else fcnt <= fcnt + 1'b1;
                end
                P_PTR: begin
                    if (ebv_ovf)       st <= P_SKIP;
                    else if (ebv_done) st <= P_LEN;
                end
                P_LEN: begin
                    len <= len_nxt;
                    if (fcnt == LEN_W'(LEN_W - 1)) begin
                        fcnt <= '0;
                        st   <= (len_nxt == '0) ? P_HDL : P_MASK;
                    end else fcnt <= fcnt + 1'b1;
                end
                P_MASK: begin
                    if (fcnt == len - 1'b1) begin
                        fcnt <= '0;
                        st   <= P_HDL;
                    end else fcnt <= fcnt + 1'b1;
                end
                P_HDL: begin
                    hdl <= {hdl[HDL_W-2:0], cmd_bit};
                    if (fcnt == LEN_W'(HDL_W - 1)) begin
                        fcnt <= '0;
                        st   <= P_DONE;
                    end else fcnt <= fcnt + 1'b1;
                end
                P_DONE:  st <= P_SKIP;
                default: st <= P_SKIP;
            endcase
        end
    end

    mrv_ebv #(.BLK_MAX(EBV_BLOCKS), .BLK_W(EBV_BLK_W)) u_ebv (
        .clk(clk), .rst_n(rst_n), .clr(cmd_end),
        .bit_vld(cmd_vld && st == P_PTR), .bit_in(cmd_bit),
        .val(ptr), .done(ebv_done), .ovf(ebv_ovf)
    );

    // One margin read per mask bit
    assign mem_rd   = cmd_vld && (st == P_MASK);
    assign mem_bank = bank;

    mrv_margin_acc #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_acc (
        .clk(clk), .rst_n(rst_n), .clr(cmd_end), .base(ptr),
        .step(mem_rd), .mask_bit(cmd_bit), .mem_bit(mem_bit),
        .mem_margin_ok(mem_margin_ok), .addr(mem_addr), .bad(mask_bad)
    );

    // Decision is taken only when a complete frame ends
    assign fire = cmd_end && (st == P_DONE);

    mrv_reply #(.HDL_W(HDL_W)) u_reply (
        .clk(clk), .rst_n(rst_n), .fire(fire), .crc_ok(crc_ok),
        .len_zero(len == '0), .hdl_match(hdl == cur_handle),
        .tag_active(tag_active), .pwr_good(pwr_good),
        .lock_hit(rsv_rd_lock && bank == BANK_RSV), .mask_bad(mask_bad),
        .hdl(hdl), .rsp_vld(rsp_vld), .rsp_hdr(rsp_hdr),
        .rsp_code(rsp_code), .rsp_handle(rsp_handle)
    );

    // R11: the reply is a single-cycle pulse that follows a frame end
    p_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_vld |=> !rsp_vld);
    p_after_end_r11: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_vld |-> $past(cmd_end));
    // R7: an inactive tag never replies
    p_inactive_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_end && !tag_active) |=> !rsp_vld);
    // R5: a zero length never replies
    p_len_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_end && len == '0) |=> !rsp_vld);
endmodule

// File: tb/tb_mrv_engine.sv
module tb_mrv_engine;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_vld = 1'b0, cmd_bit = 1'b0, cmd_end = 1'b0;
    logic        crc_ok = 1'b1, tag_active = 1'b1, pwr_good = 1'b1, rsv_rd_lock = 1'b0;
    logic [15:0] cur_handle = 16'hBEEF;
    logic        mem_rd, mem_bit, mem_margin_ok;
    logic [1:0]  mem_bank;
    logic [20:0] mem_addr;
    logic        rsp_vld, rsp_hdr;
    logic [7:0]  rsp_code;
    logic [15:0] rsp_handle;
    int          total = 0, bad = 0;
    bit          finished = 0;
    localparam logic [15:0] OPC = 16'b1110000000000001;

    always #2.5 clk = ~clk;

    // Memory model contents and margin map
    function automatic logic mbit(logic [1:0] b, int a);
        return ((a * 5 + int'(b) * 3 + (a >> 3)) % 3) == 0;
    endfunction
    function automatic logic mok(logic [1:0] b, int a);
        return !(b == 2'b11 && (a % 97) == 13);
    endfunction
    assign mem_bit       = mbit(mem_bank, int'(mem_addr));
    assign mem_margin_ok = mok(mem_bank, int'(mem_addr));

    mrv_engine dut (.*);

    task automatic chk(bit ok, string req, int act, int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic send_bit(logic b);
        @(negedge clk);
        cmd_vld = 1'b1;
        cmd_bit = b;
    endtask

    // Send one frame and check the reply against the bench's expectation
    task automatic run_cmd(logic [15:0] op, logic [1:0] bk, int ptr, int nblk, int len,
                           logic [254:0] mask, logic [15:0] hdl, bit crc, bit act,
                           bit pwr, bit lock, int extra, string req);
        bit ign, exp_err, mis;
        logic [7:0] exp_code;
        for (int i = 15; i >= 0; i--) send_bit(op[i]);
        send_bit(bk[1]); send_bit(bk[0]);
        for (int k = 0; k < nblk; k++) begin
            int d = (ptr >> (7 * (nblk - 1 - k))) & 8'h7F;
            send_bit(k < nblk - 1);
            for (int j = 6; j >= 0; j--) send_bit(d[j]);
        end
        for (int j = 7; j >= 0; j--) send_bit(len[j]);
        for (int i = 0; i < len; i++) send_bit(mask[i]);
        for (int j = 15; j >= 0; j--) send_bit(hdl[j]);
        for (int i = 0; i < extra; i++) send_bit(1'b0);
        @(negedge clk);
        cmd_vld = 1'b0; cmd_end = 1'b1;
        crc_ok = crc; tag_active = act; pwr_good = pwr; rsv_rd_lock = lock;
        @(negedge clk);
        cmd_end = 1'b0;
        mis = 1'b0;
        for (int i = 0; i < len; i++)
            if (mask[i] != mbit(bk, ptr + i) || !mok(bk, ptr + i)) mis = 1'b1;
        ign = (op != OPC) || (nblk > 3) || (len == 0) || (hdl != cur_handle) ||
              !crc || !act || (extra > 0);
        exp_err = !pwr || (lock && bk == 2'b00) || mis;
        exp_code = !pwr ? 8'h0B : 8'h00;
        chk(rsp_vld == !ign, req, rsp_vld, !ign);
        if (!ign && rsp_vld) begin
            chk(rsp_hdr == exp_err, req, rsp_hdr, exp_err);
            if (exp_err) chk(rsp_code == exp_code, req, rsp_code, exp_code);
            chk(rsp_handle == hdl, "R11", rsp_handle, hdl);
        end
        @(negedge clk);
        chk(rsp_vld == 1'b0, "R11", rsp_vld, 0);
        crc_ok = 1'b1; tag_active = 1'b1; pwr_good = 1'b1; rsv_rd_lock = 1'b0;
    endtask

    function automatic logic [254:0] good_mask(logic [1:0] b, int ptr, int len);
        logic [254:0] m = '0;
        for (int i = 0; i < len; i++) m[i] = mbit(b, ptr + i);
        return m;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog act=0 exp=1");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [254:0] m;
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(rsp_vld == 1'b0, "R1", rsp_vld, 0);
        // R3 / R11: matching EPC mask passes
        run_cmd(OPC, 2'b01, 32, 1, 16, good_mask(2'b01, 32, 16), 16'hBEEF, 1, 1, 1, 0, 0, "R3");
        // R9: one flipped bit
        m = good_mask(2'b01, 32, 16); m[7] = ~m[7];
        run_cmd(OPC, 2'b01, 32, 1, 16, m, 16'hBEEF, 1, 1, 1, 0, 0, "R9");
        // R9: weak margin at user address 13
        run_cmd(OPC, 2'b11, 10, 1, 8, good_mask(2'b11, 10, 8), 16'hBEEF, 1, 1, 1, 0, 0, "R9");
        run_cmd(OPC, 2'b01, 5, 1, 0, '0, 16'hBEEF, 1, 1, 1, 0, 0, "R5");
        run_cmd(16'hE002, 2'b01, 5, 1, 4, good_mask(2'b01, 5, 4), 16'hBEEF, 1, 1, 1, 0, 0, "R2");
        run_cmd(OPC, 2'b01, 5, 1, 4, good_mask(2'b01, 5, 4), 16'h1234, 1, 1, 1, 0, 0, "R6");
        run_cmd(OPC, 2'b01, 5, 1, 4, good_mask(2'b01, 5, 4), 16'hBEEF, 0, 1, 1, 0, 0, "R6");
        run_cmd(OPC, 2'b01, 5, 1, 4, good_mask(2'b01, 5, 4), 16'hBEEF, 1, 1, 1, 0, 1, "R6");
        run_cmd(OPC, 2'b01, 5, 1, 4, good_mask(2'b01, 5, 4), 16'hBEEF, 1, 0, 1, 0, 0, "R7");
        // R8: low power wins over a mismatching mask
        run_cmd(OPC, 2'b01, 5, 1, 4, ~good_mask(2'b01, 5, 4), 16'hBEEF, 1, 1, 0, 0, 0, "R8");
        run_cmd(OPC, 2'b00, 0, 1, 32, good_mask(2'b00, 0, 32), 16'hBEEF, 1, 1, 1, 1, 0, "R10");
        run_cmd(OPC, 2'b00, 0, 1, 32, good_mask(2'b00, 0, 32), 16'hBEEF, 1, 1, 1, 0, 0, "R10");
        run_cmd(OPC, 2'b10, 200, 2, 12, good_mask(2'b10, 200, 12), 16'hBEEF, 1, 1, 1, 0, 0, "R4");
        run_cmd(OPC, 2'b10, 20000, 3, 12, good_mask(2'b10, 20000, 12), 16'hBEEF, 1, 1, 1, 0, 0, "R4");
        run_cmd(OPC, 2'b10, 5, 4, 12, good_mask(2'b10, 5, 12), 16'hBEEF, 1, 1, 1, 0, 0, "R4");
        run_cmd(OPC, 2'b01, 300, 2, 255, good_mask(2'b01, 300, 255), 16'hBEEF, 1, 1, 1, 0, 0, "R5");
        // Random mix
        for (int n = 0; n < 150; n++) begin
            logic [1:0] bk = 2'($urandom_range(0, 3));
            int ptr = $urandom_range(0, 3000);
            int len = $urandom_range(1, 40);
            int nb = (ptr < 128) ? 1 : 2;
            m = good_mask(bk, ptr, len);
            if ($urandom_range(0, 3) == 0) m[$urandom_range(0, len - 1)] ^= 1'b1;
            run_cmd(OPC, bk, ptr, nb, len, m,
                    ($urandom_range(0, 9) == 0) ? 16'h0F0F : 16'hBEEF,
                    $urandom_range(0, 9) != 0, $urandom_range(0, 9) != 0,
                    $urandom_range(0, 5) != 0, $urandom_range(0, 3) == 0,
                    0, "R9/R8");
        end
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule